// File: doc/BRIEF.md
# Ping-Pong Byte Streamer

The block sends a continuous byte stream that it reads from two memory buffers in turn. Each buffer is a run of packed words, four bytes to a word. Software gives each buffer a word-address pointer and a length in words, then sets the run bit. The block fetches words through an in-order read port and holds them in a small prefetch queue. It then puts one byte on its output in every clock, taken from consecutive byte addresses.

When the last byte of a buffer has left the block, that buffer's empty flag is set and the stream goes straight on from the other buffer. Software refills the drained buffer by rewriting its pointer. If the fetcher comes back to a buffer whose pointer has not been rewritten since its last use, an underrun flag is set and the old pointer and length are used again. A one-clock strobe comes one clock ahead of the first valid byte. A level interrupt stays high while any enabled flag is set.

Top module: `pingpong_byte_streamer`

## Requirements
- R1: After reset, out_valid, pre_start, irq, mem_req, stat_empty and stat_urun are all low.
- R2: While running, the block outputs one byte per clock with no gaps. Byte k of a word (k = 0..3) is taken from bits [8k+7:8k], and the word sits at word address pointer + i. The byte sequence is therefore the little-endian order of successive byte addresses starting at 4 × pointer.
- R3: In the clock right after the final byte of one buffer, out_byte carries the first byte of the other buffer. Buffer 0 is streamed first after run is set.
- R4: A buffer's empty flag (stat_empty bit 0 for buffer 0, bit 1 for buffer 1) goes high in the clock after that buffer's final byte is on out_byte.
- R5: irq is high exactly while some status flag is set whose enable bit is also set. A set flag whose enable bit is clear keeps irq low.
- R6: Writing 1 to an acknowledge bit clears the matching flag. Writing 0 to it leaves the flag unchanged.
- R7: The fetcher may start a buffer whose pointer has not been written since that buffer was last started. When it does, stat_urun is set and the stream repeats the bytes at the old pointer.
- R8: pre_start is high for exactly one clock. That clock is the one just before the first valid byte after run is set.
- R9: Once run is cleared, out_valid and pre_start fall within two clocks and stay low.
- R10: Register map on cfg_addr:
  - 0: buffer 0 pointer (word address).
  - 1: buffer 0 length (words).
  - 2: buffer 1 pointer.
  - 3: buffer 1 length.
  - 4: control. Bit 0 is run. Bit 1 enables irq for empty 0, bit 2 for empty 1, bit 3 for underrun.
  - 5: acknowledge. Bit 0 clears empty 0, bit 1 clears empty 1, bit 2 clears underrun.
- R11: A buffer length of 0 words is sent as a single word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Word read request |
| mem_addr | output | ADDR_W | Word address of the request |
| mem_ready | input | 1 | Request accepted this clock |
| mem_rvalid | input | 1 | Read data returned (in request order) |
| mem_rdata | input | LANES*BYTE_W | Returned word |
| out_byte | output | BYTE_W | Streamed byte |
| out_valid | output | 1 | out_byte carries a valid byte |
| pre_start | output | 1 | Strobe one clock ahead of the first byte |
| stat_empty | output | 2 | Per-buffer empty flags |
| stat_urun | output | 1 | Underrun flag |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to produce from the ports is an underrun. The fetcher must wrap back to a buffer whose pointer has not been rewritten, and then the repeated bytes have to be seen in the output. The stimulus writes both pointers once and keeps run set past the end of the second buffer. The prefetcher then restarts buffer 0 on its stale pointer, and the bench checks the four bytes after the second buffer against the first word of buffer 0. Gap-free output is checked by timestamping every byte and requiring consecutive clocks, including across both buffer boundaries.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

   typedef enum logic [2:0] {
      SEL_PTR0 = 3'd0,
      SEL_LEN0 = 3'd1,
      SEL_PTR1 = 3'd2,
      SEL_LEN1 = 3'd3,
      SEL_CTRL = 3'd4,
      SEL_ACK  = 3'd5
   } reg_sel_e;

   typedef enum logic {
      UNP_IDLE = 1'b0,
      UNP_RUN  = 1'b1
   } unp_state_e;

   typedef struct packed {
      logic id;
      logic last;
   } word_tag_t;

endpackage

// File: rtl/pbs_fifo.sv
module pbs_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 4,
   parameter int CW    = $clog2(DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             empty,
   output logic             full,
   output logic [CW-1:0]    count
);
   localparam int PW = $clog2(DEPTH);

   if (DEPTH < 2) begin : g_depth_small
      $error("pbs_fifo: DEPTH must be at least 2");
   end
   if ((DEPTH & (DEPTH - 1)) != 0) begin : g_depth_pow2
      $error("pbs_fifo: DEPTH must be a power of two");
   end

   logic [WIDTH-1:0] store [DEPTH];
   logic [PW-1:0]    wp, rp;
   logic             do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign do_push = push && !full && !flush;
   assign do_pop  = pop && !empty && !flush;
   assign dout    = store[rp];

   always_ff @(posedge clk) begin
      if (do_push) store[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else if (flush) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         count <= count + CW'(do_push) - CW'(do_pop);
      end
   end
endmodule

// File: rtl/pbs_regs.sv
module pbs_regs
   import pbs_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int LEN_W  = 12
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_we,
   input  logic [2:0]             cfg_addr,
   input  logic [31:0]            cfg_wdata,
   input  logic [1:0]             evt_empty,
   input  logic                   evt_urun,
   input  logic [1:0]             consume,
   output logic [1:0][ADDR_W-1:0] buf_ptr,
   output logic [1:0][LEN_W-1:0]  buf_len,
   output logic [1:0]             fresh,
   output logic                   run,
   output logic [1:0]             stat_empty,
   output logic                   stat_urun,
   output logic                   irq
);
   localparam int CTRL_W = 4;

   logic [CTRL_W-2:0] irq_en;
   logic              ack_wr, ctrl_wr;
   logic              unused_wdata;

   assign ack_wr       = cfg_we && (cfg_addr == SEL_ACK);
   assign ctrl_wr      = cfg_we && (cfg_addr == SEL_CTRL);
   assign unused_wdata = ^cfg_wdata;

   for (genvar b = 0; b < 2; b++) begin : g_buf
      logic              ptr_wr, len_wr;
      logic [ADDR_W-1:0] ptr_q;
      logic [LEN_W-1:0]  len_q;
      logic              fresh_q, empty_q;

      assign ptr_wr = cfg_we && (cfg_addr == 3'(2 * b));
      assign len_wr = cfg_we && (cfg_addr == 3'(2 * b + 1));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ptr_q   <= '0;
            len_q   <= '0;
            fresh_q <= 1'b0;
            empty_q <= 1'b0;
         end else begin
            if (ptr_wr) ptr_q <= cfg_wdata[ADDR_W-1:0];
            if (len_wr) len_q <= cfg_wdata[LEN_W-1:0];
            if (ptr_wr)          fresh_q <= 1'b1;
            else if (consume[b]) fresh_q <= 1'b0;
            if (evt_empty[b])                  empty_q <= 1'b1;
            else if (ack_wr && cfg_wdata[b])   empty_q <= 1'b0;
         end
      end

      assign buf_ptr[b]    = ptr_q;
      assign buf_len[b]    = len_q;
      assign fresh[b]      = fresh_q;
      assign stat_empty[b] = empty_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run       <= 1'b0;
         irq_en    <= '0;
         stat_urun <= 1'b0;
      end else begin
         if (ctrl_wr) begin
            run    <= cfg_wdata[0];
            irq_en <= cfg_wdata[CTRL_W-1:1];
         end
         if (evt_urun)                   stat_urun <= 1'b1;
         else if (ack_wr && cfg_wdata[2]) stat_urun <= 1'b0;
      end
   end

   assign irq = |({stat_urun, stat_empty} & irq_en);
endmodule

// File: rtl/pbs_fetch.sv
module pbs_fetch #(
   parameter int ADDR_W = 16,
   parameter int LEN_W  = 12
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   run,
   input  logic                   drained,
   input  logic                   room,
   input  logic                   mem_ready,
   input  logic [1:0][ADDR_W-1:0] buf_ptr,
   input  logic [1:0][LEN_W-1:0]  buf_len,
   input  logic [1:0]             fresh,
   output logic                   mem_req,
   output logic [ADDR_W-1:0]      mem_addr,
   output logic                   tag_id,
   output logic                   tag_last,
   output logic [1:0]             consume,
   output logic                   evt_urun
);
   logic              active, cur;
   logic [ADDR_W-1:0] base;
   logic [LEN_W-1:0]  wlen, idx;
   logic              accept, last_word, load, load_sel;

   assign mem_req   = active && run && room;
   assign accept    = mem_req && mem_ready;
   assign last_word = ({1'b0, idx} + (LEN_W + 1)'(1)) >= {1'b0, wlen};
   assign load      = (run && !active && drained) || (accept && last_word);
   assign load_sel  = active ? ~cur : 1'b0;
   assign consume   = load ? (load_sel ? 2'b10 : 2'b01) : 2'b00;
   assign evt_urun  = load && !fresh[load_sel];
   assign mem_addr  = base + ADDR_W'(idx);
   assign tag_id    = cur;
   assign tag_last  = last_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cur    <= 1'b0;
         base   <= '0;
         wlen   <= '0;
         idx    <= '0;
      end else if (!run) begin
         active <= 1'b0;
      end else if (load) begin
         active <= 1'b1;
         cur    <= load_sel;
         base   <= buf_ptr[load_sel];
         wlen   <= buf_len[load_sel];
         idx    <= '0;
      end else if (accept) begin
         idx <= idx + 1'b1;
      end
   end
endmodule

// File: rtl/pbs_unpack.sv
module pbs_unpack
   import pbs_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int LANES  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    run,
   input  logic                    head_empty,
   input  logic [LANES*BYTE_W-1:0] head_word,
   input  word_tag_t               head_tag,
   output logic                    pop,
   output logic [BYTE_W-1:0]       out_byte,
   output logic                    out_valid,
   output logic                    pre_start,
   output logic [1:0]              evt_empty
);
   localparam int LW = $clog2(LANES);

   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_lanes_chk
      $error("pbs_unpack: LANES must be a power of two of at least 2");
   end

   logic [LANES-1:0][BYTE_W-1:0] lane_bytes;
   unp_state_e                   state;
   logic [LW-1:0]                lane;
   logic                         at_end, emit;

   assign lane_bytes = head_word;
   assign at_end     = (lane == LW'(LANES - 1));
   assign emit       = run && (state == UNP_RUN) && !head_empty;
   assign pop        = emit && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= UNP_IDLE;
         lane      <= '0;
         out_byte  <= '0;
         out_valid <= 1'b0;
         pre_start <= 1'b0;
         evt_empty <= '0;
      end else begin
         out_valid <= 1'b0;
         pre_start <= 1'b0;
         evt_empty <= '0;
         if (!run) begin
            state <= UNP_IDLE;
            lane  <= '0;
         end else if (state == UNP_IDLE) begin
            if (!head_empty) begin
               state     <= UNP_RUN;
               pre_start <= 1'b1;
            end
         end else if (emit) begin
            out_valid <= 1'b1;
            out_byte  <= lane_bytes[lane];
            lane      <= lane + 1'b1;
            if (at_end && head_tag.last) evt_empty[head_tag.id] <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/pingpong_byte_streamer.sv
module pingpong_byte_streamer
   import pbs_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int LEN_W      = 12,
   parameter int FIFO_DEPTH = 4,
   parameter int BYTE_W     = 8,
   parameter int LANES      = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_we,
   input  logic [2:0]              cfg_addr,
   input  logic [31:0]             cfg_wdata,
   output logic                    mem_req,
   output logic [ADDR_W-1:0]       mem_addr,
   input  logic                    mem_ready,
   input  logic                    mem_rvalid,
   input  logic [LANES*BYTE_W-1:0] mem_rdata,
   output logic [BYTE_W-1:0]       out_byte,
   output logic                    out_valid,
   output logic                    pre_start,
   output logic [1:0]              stat_empty,
   output logic                    stat_urun,
   output logic                    irq
);
   localparam int WORD_W  = LANES * BYTE_W;
   localparam int TAG_W   = $bits(word_tag_t);
   localparam int ENTRY_W = TAG_W + WORD_W;
   localparam int CNT_W   = $clog2(FIFO_DEPTH) + 1;

   if (ADDR_W < 1 || ADDR_W > 32) begin : g_addr_chk
      $error("pingpong_byte_streamer: ADDR_W must be 1..32");
   end
   if (LEN_W < 1 || LEN_W > 32) begin : g_len_chk
      $error("pingpong_byte_streamer: LEN_W must be 1..32");
   end

   logic [1:0][ADDR_W-1:0] buf_ptr;
   logic [1:0][LEN_W-1:0]  buf_len;
   logic [1:0]             fresh, consume, evt_empty;
   logic                   run_q, evt_urun;
   logic                   tag_id, tag_last, room;
   logic                   tag_empty, tag_full, dempty, dfull, dpush, upop;
   logic [CNT_W-1:0]       tcount, dcount;
   word_tag_t              tag_in, tag_out;
   logic [ENTRY_W-1:0]     dhead;
   word_tag_t              head_tag;

   pbs_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .evt_empty(evt_empty), .evt_urun(evt_urun),
      .consume(consume), .buf_ptr(buf_ptr), .buf_len(buf_len), .fresh(fresh),
      .run(run_q), .stat_empty(stat_empty), .stat_urun(stat_urun), .irq(irq)
   );

   assign room = ({1'b0, tcount} + {1'b0, dcount}) < (CNT_W + 1)'(FIFO_DEPTH);

   pbs_fetch #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_fetch (
      .clk(clk), .rst_n(rst_n), .run(run_q), .drained(tag_empty), .room(room),
      .mem_ready(mem_ready), .buf_ptr(buf_ptr), .buf_len(buf_len), .fresh(fresh),
      .mem_req(mem_req), .mem_addr(mem_addr), .tag_id(tag_id), .tag_last(tag_last),
      .consume(consume), .evt_urun(evt_urun)
   );

   assign tag_in.id   = tag_id;
   assign tag_in.last = tag_last;

   pbs_fifo #(.WIDTH(TAG_W), .DEPTH(FIFO_DEPTH)) u_tags (
      .clk(clk), .rst_n(rst_n), .flush(1'b0), .push(mem_req && mem_ready),
      .din(tag_in), .pop(mem_rvalid), .dout(tag_out), .empty(tag_empty),
      .full(tag_full), .count(tcount)
   );

   assign dpush = mem_rvalid && run_q;

   pbs_fifo #(.WIDTH(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_words (
      .clk(clk), .rst_n(rst_n), .flush(!run_q), .push(dpush),
      .din({tag_out, mem_rdata}), .pop(upop), .dout(dhead), .empty(dempty),
      .full(dfull), .count(dcount)
   );

   assign head_tag = dhead[ENTRY_W-1 -: TAG_W];

   pbs_unpack #(.BYTE_W(BYTE_W), .LANES(LANES)) u_unpack (
      .clk(clk), .rst_n(rst_n), .run(run_q), .head_empty(dempty),
      .head_word(dhead[WORD_W-1:0]), .head_tag(head_tag), .pop(upop),
      .out_byte(out_byte), .out_valid(out_valid), .pre_start(pre_start),
      .evt_empty(evt_empty)
   );

   logic unused_full;
   assign unused_full = tag_full;
endmodule

// File: rtl/pbs_checker.sv
module pbs_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       run,
   input logic       pre_start,
   input logic       out_valid,
   input logic       irq,
   input logic [1:0] stat_empty,
   input logic       stat_urun,
   input logic       dpush,
   input logic       dfull,
   input logic [1:0] evt_empty,
   input logic       ack_we,
   input logic [2:0] ack_bits
);
   AST_PRE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      pre_start |=> !pre_start); // R8
   AST_PRE_LEADS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      pre_start && run |=> out_valid); // R8
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      dpush |-> !dfull); // R2
   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (stat_empty != 2'b00 || stat_urun)); // R5
   AST_QUIET_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !out_valid && !pre_start); // R9
   AST_EMPTY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      evt_empty[0] |=> stat_empty[0]); // R4
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ack_we && ack_bits[1] && !evt_empty[1] |=> !stat_empty[1]); // R6
endmodule

bind pingpong_byte_streamer pbs_checker u_chk (
   .clk(clk), .rst_n(rst_n), .run(run_q), .pre_start(pre_start),
   .out_valid(out_valid), .irq(irq), .stat_empty(stat_empty),
   .stat_urun(stat_urun), .dpush(dpush), .dfull(dfull), .evt_empty(evt_empty),
   .ack_we(cfg_we && cfg_addr == 3'd5), .ack_bits(cfg_wdata[2:0])
);

// File: tb/test_pingpong_byte_streamer.sv
module test_pingpong_byte_streamer;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;
   localparam int AW         = 16;

   typedef struct packed {
      logic [15:0] pa;
      logic [11:0] la;
      logic [15:0] pb;
      logic [11:0] lb;
      logic [2:0]  ie;
   } vec_t;

   localparam int NVEC = 4;
   localparam vec_t VECS [NVEC] = '{
      '{16'h0010, 12'd2, 16'h0100, 12'd3, 3'b001},
      '{16'h0200, 12'd1, 16'h0008, 12'd1, 3'b000},
      '{16'h0FF0, 12'd4, 16'h0020, 12'd2, 3'b100},
      '{16'h0040, 12'd0, 16'h0041, 12'd5, 3'b110}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        mem_req, mem_ready, mem_rvalid;
   logic [AW-1:0] mem_addr;
   logic [31:0] mem_rdata;
   logic [7:0]  out_byte;
   logic        out_valid, pre_start, stat_urun, irq;
   logic [1:0]  stat_empty;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   pingpong_byte_streamer i_pingpong_byte_streamer (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .out_byte(out_byte), .out_valid(out_valid), .pre_start(pre_start),
      .stat_empty(stat_empty), .stat_urun(stat_urun), .irq(irq)
   );

   function automatic logic [7:0] bval(input int a);
      return 8'(a * 7 + 3);
   endfunction

   function automatic logic [31:0] word_at(input int w);
      return {bval(4 * w + 3), bval(4 * w + 2), bval(4 * w + 1), bval(4 * w)};
   endfunction

   // Memory model: always ready, data two clocks after acceptance, in order.
   logic          p1_v, p2_v;
   logic [AW-1:0] p1_a, p2_a;
   assign mem_ready  = 1'b1;
   assign mem_rvalid = p2_v;
   assign mem_rdata  = word_at(int'(p2_a));

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p1_v <= 1'b0; p2_v <= 1'b0; p1_a <= '0; p2_a <= '0;
      end else begin
         p1_v <= mem_req && mem_ready;
         p1_a <= mem_addr;
         p2_v <= p1_v;
         p2_a <= p1_a;
      end
   end

   // Output collector, sampled on the falling edge.
   bit collecting = 1'b0;
   int cyc, n, pre_at, e0_at, e1_at;
   int got [64];
   int at  [64];

   always @(negedge clk) begin
      if (collecting) begin
         cyc++;
         if (pre_start && pre_at < 0) pre_at = cyc;
         if (out_valid && n < 64) begin
            got[n] = int'(out_byte);
            at[n]  = cyc;
            n++;
         end
         if (stat_empty[0] && e0_at < 0) e0_at = cyc;
         if (stat_empty[1] && e1_at < 0) e1_at = cyc;
      end
   end

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input int sel, input int data);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_addr  = 3'(sel);
      cfg_wdata = 32'(data);
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   task automatic start_collect();
      cyc = 0; n = 0; pre_at = -1; e0_at = -1; e1_at = -1;
      collecting = 1'b1;
   endtask

   task automatic run_vec(input vec_t v);
      int wa, wb, nb, bad;
      wa = (v.la == 0) ? 1 : int'(v.la);  // R11: zero length sends one word
      wb = (v.lb == 0) ? 1 : int'(v.lb);
      nb = 4 * (wa + wb);
      do_reset();
      wr(0, int'(v.pa)); wr(1, int'(v.la)); wr(2, int'(v.pb)); wr(3, int'(v.lb));
      start_collect();
      wr(4, int'({v.ie, 1'b1}));
      for (int k = 0; k < 3000 && n < nb + 4; k++) @(negedge clk);
      repeat (2) @(negedge clk);
      collecting = 1'b0;
      check(n >= nb + 4, "R2", "byte count", n, nb + 4);
      bad = 0;
      for (int i = 0; i < nb; i++) begin
         int e;
         e = (i < 4 * wa) ? int'(bval(4 * int'(v.pa) + i))
                          : int'(bval(4 * int'(v.pb) + i - 4 * wa));
         if (got[i] != e) bad++;
      end
      check(bad == 0, "R2", "mismatched bytes", bad, 0);
      check(got[4 * wa] == int'(bval(4 * int'(v.pb))), "R3", "first byte of other buffer",
            got[4 * wa], int'(bval(4 * int'(v.pb))));
      check(at[4 * wa] == at[4 * wa - 1] + 1, "R3", "switch cycle", at[4 * wa], at[4 * wa - 1] + 1);
      bad = 0;
      for (int i = 0; i < nb + 4; i++) if (at[i] != at[0] + i) bad++;
      check(bad == 0, "R2", "gaps in stream", bad, 0);
      check(pre_at == at[0] - 1, "R8", "strobe cycle", pre_at, at[0] - 1);
      check(e0_at == at[4 * wa - 1] + 1, "R4", "empty0 cycle", e0_at, at[4 * wa - 1] + 1);
      check(e1_at == at[nb - 1] + 1, "R4", "empty1 cycle", e1_at, at[nb - 1] + 1);
      bad = 0;
      for (int i = 0; i < 4; i++) if (got[nb + i] != int'(bval(4 * int'(v.pa) + i))) bad++;
      check(bad == 0, "R7", "reused pointer bytes", bad, 0);
      check(stat_urun == 1'b1, "R7", "underrun flag", int'(stat_urun), 1);
      check(irq == (v.ie != 3'b000), "R5", "irq level", int'(irq), int'(v.ie != 3'b000));
      wr(4, int'({v.ie, 1'b0}));
      repeat (2) @(negedge clk);
      check(!out_valid && !pre_start, "R9", "outputs after stop", int'(out_valid), 0);
      bad = 0;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         if (out_valid || pre_start) bad++;
      end
      check(bad == 0, "R9", "activity while stopped", bad, 0);
   endtask

   initial begin : watchdog
      repeat (WATCHDOG) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got %0d expected 0 remaining cycles", WATCHDOG);
      finish_run();
   end

   initial begin : main
      // R1: reset state
      repeat (2) @(negedge clk);
      check(!out_valid && !pre_start && !irq && !mem_req, "R1", "outputs in reset",
            int'({out_valid, pre_start, irq, mem_req}), 0);
      do_reset();
      check({stat_empty, stat_urun} == 3'b000, "R1", "flags after reset",
            int'({stat_empty, stat_urun}), 0);
      check(!out_valid && !mem_req, "R1", "idle after reset", int'({out_valid, mem_req}), 0);

      // R10: vector table drives the register map for every case
      for (int vi = 0; vi < NVEC; vi++) run_vec(VECS[vi]);

      // R6 / R5: acknowledge behaviour, flags all set, irq enables = empty0 only
      run_vec(VECS[0]);
      wr(5, 0);
      check({stat_urun, stat_empty} == 3'b111, "R6", "ack of zeros", int'({stat_urun, stat_empty}), 7);
      wr(5, 2);
      check({stat_urun, stat_empty} == 3'b101, "R6", "ack empty1", int'({stat_urun, stat_empty}), 5);
      check(irq == 1'b1, "R5", "irq with empty0 enabled", int'(irq), 1);
      wr(5, 1);
      check({stat_urun, stat_empty} == 3'b100, "R6", "ack empty0", int'({stat_urun, stat_empty}), 4);
      check(irq == 1'b0, "R5", "urun set but not enabled", int'(irq), 0);
      wr(5, 4);
      check({stat_urun, stat_empty} == 3'b000, "R6", "ack urun", int'({stat_urun, stat_empty}), 0);

      // R8: restart after stop emits a fresh strobe and fresh data
      wr(0, 16'h0300);
      start_collect();
      wr(4, 1);
      for (int k = 0; k < 200 && n < 4; k++) @(negedge clk);
      collecting = 1'b0;
      check(n >= 4 && pre_at == at[0] - 1, "R8", "restart strobe", pre_at, at[0] - 1);
      check(got[0] == int'(bval(4 * 16'h0300)), "R2", "restart first byte",
            got[0], int'(bval(4 * 16'h0300)));
      check(got[3] == int'(bval(4 * 16'h0300 + 3)), "R2", "restart fourth byte",
            got[3], int'(bval(4 * 16'h0300 + 3)));
      wr(4, 0);
      repeat (3) @(negedge clk);
      check(!out_valid, "R9", "stopped after restart", int'(out_valid), 0);

      finish_run();
   end
endmodule